// File: doc/BRIEF.md
# Bit-Serial Host Register Port

This block is the slave side of a three-wire serial link between a host microcontroller and a radio receiver. The host supplies a transfer clock, an active-high enable and shares one open-drain data line with the port. Through this link the host can write a nine-bit setup word, read that word back, read a four-bit receiver status, and read a 128-bit received-message buffer. The setup word drives the receiver's gain, band and sleep-interval settings. The message buffer is filled by a packet decoder through a one-cycle load port.

Every transfer opens with a two-bit opcode, most significant bit first. For a write, the setup bits follow directly after the opcode. For a read, the port leaves the line released for one extra host clock. It then drives the selected word, least significant bit first. All three host signals are synchronised into the system clock. The port samples incoming bits on host rising edges and changes its outgoing bit on host falling edges. A completed message read clears the data-ready flag. Dropping the enable aborts the transfer at any point.

Top module: `hsp_port`

## Requirements
- R1: The first two host bits of a transfer form the opcode, first bit as MSB: 01 writes the setup, 00 reads the setup, 10 reads the status, 11 reads the message buffer.
- R2: A write carries nine bits after the opcode in the order gain-select, band bit 1, band bit 0, sleep bits 5 down to 0. These appear on `lna_o`, `band_o`, `sleep_o` only after the ninth bit. All three outputs reset to zero.
- R3: On every read the line stays released for the whole host clock that follows the opcode. The first data bit is driven only from the next falling edge.
- R4: A setup read returns the nine setup bits in the same order in which a write sends them.
- R5: A status read returns four bits in the order data-ready, receiver-busy (`rx_busy_i`), quality bit 1, quality bit 0 (`rq_i`).
- R6: A message read returns 128 bits, byte 0 first, each byte LSB first. Bit k of the transfer is `msg_data_i[k]` of the stored message.
- R7: A load pulse stores the message and sets `dr_o`. A message read that delivers all 128 bits clears `dr_o`, unless a new load arrived after that read began.
- R8: The message is copied into the transmit shifter when the read starts, so a load during the read does not alter the bits returned.
- R9: Deasserting the enable releases the line and restarts bit counting. A write cut short leaves the setup unchanged. A message read cut short leaves `dr_o` set.
- R10: The port only ever pulls the line low (`d_pull_low_o` = 1) to send a 0 and releases it for a 1. It is released out of reset and between transfers.
- R11: The port samples input bits on host rising edges and changes its output only on host falling edges, so a driven bit is stable while the host clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| d_clk_i | input | 1 | Host transfer clock (asynchronous) |
| d_en_i | input | 1 | Host transfer enable, active high |
| d_line_i | input | 1 | Level seen on the shared open-drain data line |
| d_pull_low_o | output | 1 | 1 pulls the data line low, 0 releases it |
| msg_load_i | input | 1 | One-cycle pulse that stores a new message |
| msg_data_i | input | MSG_BYTES*8 | Message contents, byte 0 in bits 7:0 |
| rx_busy_i | input | 1 | Receiver-busy flag reported in the status |
| rq_i | input | 2 | Signal-quality code reported in the status |
| lna_o | output | 1 | Gain select: 0 full gain, 1 reduced gain |
| band_o | output | 2 | Band code: 00 868.3 MHz, 01 433.92 MHz, 10 315 MHz, 11 unused |
| sleep_o | output | 6 | Sleep-interval code |
| dr_o | output | 1 | Data-ready flag |

## Verification
The bench sweeps a spread of setup values through write and readback. A design with the field order reversed or rotated would show a mismatch on the outputs or in the echoed bits. Every read checks the gap clock with a first data bit of 0, so a port that drives one clock early shows a low where the line must be high. Reads are also cut short, and a load is injected in the middle of a message read. A port without a snapshot would return a mixture of two messages. A port that clears the flag unconditionally would lose the newer message's ready indication. A port that commits a partial write would change the setup.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

    typedef enum logic [1:0] {
        OP_RD_SETUP = 2'b00,
        OP_WR_SETUP = 2'b01,
        OP_RD_STAT  = 2'b10,
        OP_RD_MSG   = 2'b11
    } op_e;

    typedef struct packed {
        logic       lna;
        logic [1:0] band;
        logic [5:0] sleep;
    } setup_t;

    localparam int OP_W       = 2;
    localparam int GAP_W      = 1;
    localparam int SETUP_W    = $bits(setup_t);
    localparam int STAT_W     = 4;
    localparam int DATA_START = OP_W + GAP_W;

    // Serial order of the setup word: element 0 leaves first.
    function automatic logic [SETUP_W-1:0] setup_serial(input setup_t s);
        logic [SETUP_W-1:0] v;
        logic [SETUP_W-1:0] r;
        v = s;
        for (int i = 0; i < SETUP_W; i++) r[i] = v[SETUP_W-1-i];
        return r;
    endfunction

    function automatic logic [STAT_W-1:0] status_serial(input logic dr, input logic busy,
                                                        input logic [1:0] q);
        return {q[0], q[1], busy, dr};
    endfunction

endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/hsp_msgstore.sv
module hsp_msgstore #(
    parameter int MSG_BITS = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  logic [MSG_BITS-1:0] data_i,
    input  logic                rd_start_i,
    input  logic                rd_done_i,
    output logic [MSG_BITS-1:0] msg_o,
    output logic                dr_o
);
    logic fresh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_o   <= '0;
            dr_o    <= 1'b0;
            fresh_q <= 1'b0;
        end else begin
            if (load_i) begin
                msg_o   <= data_i;
                dr_o    <= 1'b1;
                fresh_q <= 1'b1;
            end else begin
                if (rd_start_i) fresh_q <= 1'b0;
                if (rd_done_i && !fresh_q) dr_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hsp_txshift.sv
module hsp_txshift #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    input  logic         shift_i,
    output logic         bit_o
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)          sh_q <= '0;
        else if (load_i)  sh_q <= word_i;
        else if (shift_i) sh_q <= {1'b0, sh_q[W-1:1]};
    end

    assign bit_o = sh_q[0];
endmodule

// File: rtl/hsp_port.sv
module hsp_port
    import hsp_pkg::*;
#(
    parameter int MSG_BYTES   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   d_clk_i,
    input  logic                   d_en_i,
    input  logic                   d_line_i,
    output logic                   d_pull_low_o,
    input  logic                   msg_load_i,
    input  logic [MSG_BYTES*8-1:0] msg_data_i,
    input  logic                   rx_busy_i,
    input  logic [1:0]             rq_i,
    output logic                   lna_o,
    output logic [1:0]             band_o,
    output logic [5:0]             sleep_o,
    output logic                   dr_o
);
    localparam int MSG_BITS = MSG_BYTES * 8;
    localparam int LAST_CNT = DATA_START + MSG_BITS;
    localparam int CNT_W    = $clog2(LAST_CNT + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // synchronised host signals
    logic [2:0] sync_q;
    logic       clk_s, en_s, dat_s, clk_d;
    logic       rise_e, fall_e;

    hsp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({d_clk_i, d_en_i, d_line_i}),
        .q_o (sync_q)
    );
    assign {clk_s, en_s, dat_s} = sync_q;

    always_ff @(posedge clk) begin
        if (rst) clk_d <= 1'b0;
        else     clk_d <= clk_s;
    end
    assign rise_e = en_s &  clk_s & ~clk_d;
    assign fall_e = en_s & ~clk_s &  clk_d;

    // framing state
    logic [CNT_W-1:0]   cnt_q;
    logic               op_hi_q;
    op_e                op_q;
    op_e                op_now;
    logic [SETUP_W-2:0] wr_sh_q;
    setup_t             setup_q;
    logic               pull_low_q;

    logic start_e, rd_start, msg_rd_start, wr_commit, rd_done;
    logic tx_bit, tx_shift, in_window;
    logic [CNT_W-1:0] tx_len;
    logic [MSG_BITS-1:0] tx_word;
    logic [MSG_BITS-1:0] msg_q;

    assign op_now       = op_e'({op_hi_q, dat_s});
    assign start_e      = rise_e && (cnt_q == CNT_W'(OP_W - 1));
    assign rd_start     = start_e && (op_now != OP_WR_SETUP);
    assign msg_rd_start = start_e && (op_now == OP_RD_MSG);
    assign wr_commit    = rise_e && (op_q == OP_WR_SETUP)
                          && (cnt_q == CNT_W'(OP_W + SETUP_W - 1));
    assign rd_done      = rise_e && (op_q == OP_RD_MSG)
                          && (cnt_q == CNT_W'(LAST_CNT - 1));

    always_comb begin
        case (op_q)
            OP_RD_SETUP: tx_len = CNT_W'(SETUP_W);
            OP_RD_STAT:  tx_len = CNT_W'(STAT_W);
            OP_RD_MSG:   tx_len = CNT_W'(MSG_BITS);
            default:     tx_len = '0;
        endcase
    end
    assign in_window = (cnt_q >= CNT_W'(DATA_START))
                       && (cnt_q < CNT_W'(DATA_START) + tx_len);
    assign tx_shift  = fall_e && in_window && (op_q != OP_WR_SETUP);

    always_comb begin
        tx_word = '0;
        case (op_now)
            OP_RD_SETUP: tx_word[SETUP_W-1:0] = setup_serial(setup_q);
            OP_RD_STAT:  tx_word[STAT_W-1:0]  = status_serial(dr_o, rx_busy_i, rq_i);
            OP_RD_MSG:   tx_word              = msg_q;
            default:     tx_word              = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            op_hi_q    <= 1'b0;
            op_q       <= OP_RD_SETUP;
            wr_sh_q    <= '0;
            setup_q    <= '0;
            pull_low_q <= 1'b0;
        end else if (!en_s) begin
            cnt_q      <= '0;
            op_q       <= OP_RD_SETUP;
            pull_low_q <= 1'b0;
        end else if (rise_e) begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            if (cnt_q == '0) op_hi_q <= dat_s;
            if (start_e)     op_q    <= op_now;
            wr_sh_q <= {wr_sh_q[SETUP_W-3:0], dat_s};
            if (wr_commit)   setup_q <= setup_t'({wr_sh_q, dat_s});
        end else if (fall_e) begin
            pull_low_q <= tx_shift ? ~tx_bit : 1'b0;
        end
    end

    hsp_txshift #(.W(MSG_BITS)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .load_i  (rd_start),
        .word_i  (tx_word),
        .shift_i (tx_shift),
        .bit_o   (tx_bit)
    );

    hsp_msgstore #(.MSG_BITS(MSG_BITS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .load_i     (msg_load_i),
        .data_i     (msg_data_i),
        .rd_start_i (msg_rd_start),
        .rd_done_i  (rd_done),
        .msg_o      (msg_q),
        .dr_o       (dr_o)
    );

    assign d_pull_low_o = pull_low_q;
    assign lna_o        = setup_q.lna;
    assign band_o       = setup_q.band;
    assign sleep_o      = setup_q.sleep;
endmodule

// File: rtl/hsp_port_chk.sv
module hsp_port_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en_s,
    input logic             fall_e,
    input logic             wr_commit,
    input logic             pull_low,
    input logic [8:0]       setup_q,
    input logic             msg_load,
    input logic             dr,
    input logic [CNT_W-1:0] cnt_q
);
    // R9: enable low releases the line on the next cycle
    a_r9_release_on_abort: assert property (@(posedge clk) disable iff (rst)
        !en_s |=> !pull_low);

    // R2: setup changes only when a complete write commits
    a_r2_setup_commit_only: assert property (@(posedge clk) disable iff (rst)
        !wr_commit |=> $stable(setup_q));

    // R11: the line driver only moves on a host falling edge or an abort
    a_r11_drive_on_fall: assert property (@(posedge clk) disable iff (rst)
        !(fall_e || !en_s) |=> $stable(pull_low));

    // R7: a load always leaves the flag set
    a_r7_load_sets_dr: assert property (@(posedge clk) disable iff (rst)
        msg_load |=> dr);

    // R3: no drive during opcode or gap clocks
    a_r3_no_drive_in_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(pull_low) |-> (cnt_q >= CNT_W'(hsp_pkg::DATA_START)));
endmodule

bind hsp_port hsp_port_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_s      (en_s),
    .fall_e    (fall_e),
    .wr_commit (wr_commit),
    .pull_low  (pull_low_q),
    .setup_q   (setup_q),
    .msg_load  (msg_load_i),
    .dr        (dr_o),
    .cnt_q     (cnt_q)
);

// File: tb/sim_hsp_port.sv
module sim_hsp_port;
    localparam int HALF = 8;
    localparam int MB   = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic d_clk = 1'b0, d_en = 1'b0, host_low = 1'b0;
    logic dut_low, line;
    logic msg_load = 1'b0;
    logic [MB-1:0] msg_data = '0;
    logic rx_busy = 1'b0;
    logic [1:0] rq = 2'b00;
    logic lna, dr;
    logic [1:0] band;
    logic [5:0] sleep;

    assign line = !(host_low || dut_low);

    hsp_port u0 (
        .clk(clk), .rst(rst), .d_clk_i(d_clk), .d_en_i(d_en), .d_line_i(line),
        .d_pull_low_o(dut_low), .msg_load_i(msg_load), .msg_data_i(msg_data),
        .rx_busy_i(rx_busy), .rq_i(rq), .lna_o(lna), .band_o(band),
        .sleep_o(sleep), .dr_o(dr)
    );

    int checks = 0, fails = 0, hold_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [MB-1:0] act, input logic [MB-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one host clock; returns line level just before the rising edge
    task automatic clk_bit(input logic v, output logic seen);
        logic hi;
        host_low = !v;
        repeat (HALF) @(negedge clk);
        seen  = line;
        d_clk = 1'b1;
        repeat (HALF) @(negedge clk);
        hi = line;
        if (hi !== seen) hold_bad++;
        d_clk = 1'b0;
    endtask

    task automatic pulse_load(input logic [MB-1:0] m);
        msg_data = m;
        msg_load = 1'b1;
        @(negedge clk);
        msg_load = 1'b0;
    endtask

    task automatic xfer(input logic [1:0] op, input logic [8:0] wv, input int nbits,
                        input int inj_at, input logic [MB-1:0] inj,
                        output logic [MB-1:0] got, output logic gap);
        logic s;
        got = '0;
        gap = 1'b0;
        d_en = 1'b1;
        repeat (4) @(negedge clk);
        clk_bit(op[1], s);
        clk_bit(op[0], s);
        if (op == 2'b01) begin
            for (int i = 0; i < nbits; i++) clk_bit(wv[8-i], s);
        end else begin
            clk_bit(1'b1, gap);
            for (int i = 0; i < nbits; i++) begin
                if (i == inj_at) pulse_load(inj);
                clk_bit(1'b1, s);
                got[i] = s;
            end
        end
        host_low = 1'b0;
        d_en = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    function automatic logic [MB-1:0] pat(input int seed, input logic [7:0] off);
        logic [MB-1:0] p;
        for (int b = 0; b < 16; b++) p[b*8 +: 8] = 8'(b * seed) + off;
        return p;
    endfunction

    function automatic logic [8:0] ser9(input logic [8:0] v);
        logic [8:0] r;
        for (int i = 0; i < 9; i++) r[i] = v[8-i];
        return r;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [MB-1:0] got, ma, mb, mc, md;
        logic gap;
        logic [8:0] v, keep;
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // reset state
        chk({lna, band, sleep} == 9'd0, "R2", "setup after reset", MB'({lna, band, sleep}), 0);
        chk(dr == 1'b0, "R7", "dr after reset", MB'(dr), 0);
        chk(dut_low == 1'b0, "R10", "line released after reset", MB'(dut_low), 0);
        xfer(2'b00, 9'd0, 9, -1, '0, got, gap);
        chk(got[8:0] == 9'd0, "R4", "setup readback after reset", got, 0);

        // write / readback sweep; field map: v[8]=gain, v[7:6]=band, v[5:0]=sleep
        for (int i = 0; i < 65; i++) begin
            v = (i == 64) ? 9'h1FF : 9'((i * 73 + 5) % 512);
            xfer(2'b01, v, 9, -1, '0, got, gap);
            chk({lna, band, sleep} == v, "R1 R2", "setup outputs after write",
                MB'({lna, band, sleep}), MB'(v));
            xfer(2'b00, 9'd0, 9, -1, '0, got, gap);
            chk(got[8:0] == ser9(v), "R4", "setup readback order", got, MB'(ser9(v)));
            if (ser9(v)[0] == 1'b0)
                chk(gap == 1'b1, "R3", "line released in gap clock", MB'(gap), 1);
        end

        // cut-short write leaves setup unchanged
        keep = 9'h0A5;
        xfer(2'b01, keep, 9, -1, '0, got, gap);
        xfer(2'b01, 9'h15A, 5, -1, '0, got, gap);
        chk({lna, band, sleep} == keep, "R9", "partial write ignored",
            MB'({lna, band, sleep}), MB'(keep));
        chk(dut_low == 1'b0, "R9", "line released after abort", MB'(dut_low), 0);

        // status sweep, flag clear then set
        for (int f = 0; f < 2; f++) begin
            if (f == 1) pulse_load(pat(3, 8'h10));
            for (int s = 0; s < 8; s++) begin
                rx_busy = s[2];
                rq = s[1:0];
                xfer(2'b10, 9'd0, 4, -1, '0, got, gap);
                chk(got[3:0] == {rq[0], rq[1], rx_busy, 1'(f)}, "R1 R5", "status word",
                    got, MB'({rq[0], rq[1], rx_busy, 1'(f)}));
            end
        end

        // full message read, first bit 0 to expose an early drive
        ma = pat(7, 8'h5A);
        mb = pat(13, 8'hA5);
        mc = pat(29, 8'h3C);
        md = pat(5, 8'hC3);
        pulse_load(ma);
        chk(dr == 1'b1, "R7", "dr set by load", MB'(dr), 1);
        xfer(2'b11, 9'd0, MB, -1, '0, got, gap);
        chk(got == ma, "R6", "message bits byte0 lsb first", got, ma);
        chk(gap == 1'b1, "R3", "gap before message", MB'(gap), 1);
        chk(dr == 1'b0, "R7", "dr cleared by full read", MB'(dr), 0);

        // aborted message read
        pulse_load(mb);
        xfer(2'b11, 9'd0, 60, -1, '0, got, gap);
        chk(dr == 1'b1, "R9", "dr kept after aborted read", MB'(dr), 1);
        chk(dut_low == 1'b0, "R9 R10", "line released after aborted read", MB'(dut_low), 0);
        xfer(2'b11, 9'd0, MB, -1, '0, got, gap);
        chk(got == mb, "R6", "message after abort", got, mb);

        // load arrives during a read
        pulse_load(mc);
        xfer(2'b11, 9'd0, MB, 40, md, got, gap);
        chk(got == mc, "R8", "snapshot survives load", got, mc);
        chk(dr == 1'b1, "R7", "dr kept for newer message", MB'(dr), 1);
        xfer(2'b11, 9'd0, MB, -1, '0, got, gap);
        chk(got == md, "R8", "newer message read next", got, md);
        chk(dr == 1'b0, "R7", "dr cleared after newer read", MB'(dr), 0);

        chk(hold_bad == 0, "R11", "line stable while host clock high", MB'(hold_bad), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule